// File: doc/BRIEF.md
# Reverse Ordering-Table Clear Generator

This block fills a stretch of memory with an empty list whose links run downward. A host pulses a start strobe and supplies a base byte address and a word count. The block then writes one word per list entry through a write port with a valid/ready handshake. The first write goes to the base address, and each later write goes 4 bytes lower. The word stored at each address is a pointer to the entry just below it. The lowest entry, which is the last one written, holds an end marker instead of a pointer.

A traversal that starts at the base address therefore visits every entry in turn and stops at the marker. The data pattern comes only from the destination address and the remaining count, so the block reads nothing from memory. Addresses are 24 bits wide, kept word aligned, and wrap modulo 2^24. The `busy` and `done` outputs tell the host when the fill is under way and when the final write has been accepted.

Top module: `otc_fill_gen`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done` and `memValid` are low.
- R2: When `startIn` is high and the block is not busy, `busy` and `memValid` are high one cycle later, and `memAddr` equals `baseIn` with its two low bits cleared.
- R3: After each accepted write that is not the final one, the next `memAddr` is the previous one minus 4, taken modulo 2^24. For example, 0x000000 is followed by 0xFFFFFC.
- R4: The data of every non-final write is (`memAddr` - 4) modulo 2^24 in bits 23:0, with bits 31:24 zero.
- R5: The final write of a fill carries the end marker 0x00FFFFFF.
- R6: A word count N from 1 to 2^CNT_W-1 produces exactly N accepted writes. A count of 1 produces a single end-marker write at the base address.
- R7: A word count of 0 produces 2^CNT_W writes.
- R8: While `memValid` is high and `memReady` is low, `memAddr`, `memData` and `memValid` stay unchanged on the next cycle.
- R9: `busy` stays high from the cycle after start until the cycle in which the final write is accepted. In the next cycle `done` is high for exactly one cycle, with `busy` and `memValid` low.
- R10: A `startIn` pulse that arrives while `busy` is high is ignored. The running fill keeps its addresses, its data and its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start request, taken only when not busy |
| baseIn | input | ADDR_W | Byte address of the first (highest) entry |
| countIn | input | CNT_W | Number of entries; 0 means 2^CNT_W |
| memAddr | output | ADDR_W | Write byte address |
| memData | output | DATA_W | Write data word |
| memValid | output | 1 | Write request valid |
| memReady | input | 1 | Memory accepts the write when high together with memValid |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle pulse after the final write is accepted |

## Verification
On every cycle the embedded assertions check several properties. They check that the write port holds still while it is stalled and that each accepted non-final write moves the address down by exactly one word. They also check that addresses stay aligned and that `done` follows the final acceptance as a single pulse without `busy`. The bench scenarios cover what no single-cycle property can show. These are the exact number of writes for each count (including the zero-count full range), the pointer value stored in each entry, the end marker landing on the lowest entry, wrap-around below address zero, and a start pulse during a fill leaving that fill unchanged.

// File: rtl/otc_pkg.sv
package otc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture base address and count
    logic step;   // advance to the next lower entry
  } otcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_FIN  = 2'd2
  } otcState_e;

endpackage

// File: rtl/otc_ctrl.sv
module otc_ctrl
  import otc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       memReady,
  input  logic       lastWord,
  output otcStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       memValid
);

  otcState_e state, stateNext;
  logic      accept;

  assign accept = (state == ST_FILL) && memReady;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE, ST_FIN: stateNext = startIn ? ST_FILL : ST_IDLE;
      ST_FILL:         if (accept && lastWord) stateNext = ST_FIN;
      default:         stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load = (state != ST_FILL) && startIn;
    strobe.step = accept && !lastWord;
  end

  assign busy     = (state == ST_FILL);
  assign done     = (state == ST_FIN);
  assign memValid = busy;

  // final acceptance is followed by a done cycle without busy
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memReady && lastWord) |=> (done && !busy && !memValid));

  // done never lasts two cycles
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // a running fill is not cut short or restarted by another start
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(memReady && lastWord)) |=> busy);

  // a start seen while idle always begins a fill
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startIn) |=> (busy && memValid));

endmodule

// File: rtl/otc_datapath.sv
module otc_datapath
  import otc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  otcStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [CNT_W-1:0]  countIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              lastWord
);

  localparam int PAD_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] END_MARK   = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;     // entries left after the current one
  logic [ADDR_W-1:0] linkAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
    end else if (strobe.load) begin
      curAddr <= baseIn & ALIGN_MASK;
      remain  <= countIn - CNT_W'(1);   // count 0 wraps to the full range
    end else if (strobe.step) begin
      curAddr <= curAddr - WORD_BYTES;
      remain  <= remain - CNT_W'(1);
    end
  end

  assign linkAddr = curAddr - WORD_BYTES;
  assign lastWord = (remain == '0);
  assign memAddr  = curAddr;
  assign memData  = {{PAD_W{1'b0}}, (lastWord ? END_MARK : linkAddr)};

  // each step moves exactly one word down, wrapping at zero
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=> (memAddr == $past(memAddr) - WORD_BYTES));

  // addresses stay word aligned
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memAddr[1:0] == 2'b00);

endmodule

// File: rtl/otc_fill_gen.sv
module otc_fill_gen
  import otc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [CNT_W-1:0]  countIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memValid,
  input  logic              memReady,
  output logic              busy,
  output logic              done
);

  otcStrobe_t strobe;
  logic       lastWord;

  otc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .memReady (memReady),
    .lastWord (lastWord),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .memValid (memValid)
  );

  otc_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .baseIn   (baseIn),
    .countIn  (countIn),
    .memAddr  (memAddr),
    .memData  (memData),
    .lastWord (lastWord)
  );

  // a stalled write holds address, data and valid
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));

  // upper data bits are always zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memData[DATA_W-1:ADDR_W] == '0));

  // done and busy never overlap
  assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done}));

endmodule

// File: tb/sim_otc_fill_gen.sv
`timescale 1ns/1ps
module sim_otc_fill_gen;

  localparam int ADDR_W = 24;
  localparam int CNT_W  = 6;
  localparam int DATA_W = 32;
  localparam int FULL_N = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startIn = 1'b0;
  logic [ADDR_W-1:0] baseIn = '0;
  logic [CNT_W-1:0]  countIn = '0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;
  logic              memValid;
  logic              memReady = 1'b0;
  logic              busy;
  logic              done;

  int vectors = 0;
  int fails   = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  otc_fill_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .baseIn(baseIn), .countIn(countIn),
    .memAddr(memAddr), .memData(memData), .memValid(memValid), .memReady(memReady),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runXfer(input logic [ADDR_W-1:0] base, input int cnt, input bit stall, input bit inject);
    int n;
    int k;
    int guard;
    bit pStall;
    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] pa;
    logic [DATA_W-1:0] pd;
    n = (cnt == 0) ? FULL_N : cnt;
    k = 0;
    guard = 0;
    pStall = 0;
    pa = '0;
    pd = '0;
    ea = base & 24'hFFFFFC;
    @(negedge clk);
    check(!busy, "R9 idle before start", 32'(busy), 32'd0);
    startIn = 1'b1;
    baseIn  = base;
    countIn = CNT_W'(cnt);
    memReady = 1'b0;
    @(negedge clk);
    startIn = 1'b0;
    check(busy && memValid, "R2 busy/valid after start", {30'd0, busy, memValid}, 32'd3);
    check(memAddr == ea, "R2 first address", 32'(memAddr), 32'(ea));
    while (k < n && guard < 4000) begin
      if (pStall) begin
        check(memValid && memAddr == pa, "R8 address held", 32'(memAddr), 32'(pa));
        check(memData == pd, "R8 data held", memData, pd);
      end
      // R10: start pulse with different settings during the fill
      if (inject && k == 1) begin
        startIn = 1'b1;
        baseIn  = ~base;
        countIn = CNT_W'(1);
      end else begin
        startIn = 1'b0;
      end
      memReady = stall ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (memValid && memReady) begin
        check(memAddr == ea, inject ? "R10 address after ignored start" : "R3 address sequence",
              32'(memAddr), 32'(ea));
        if (k == n - 1)
          check(memData == 32'h00FFFFFF, "R5 end marker", memData, 32'h00FFFFFF);
        else
          check(memData == {8'd0, ea - 24'd4}, "R4 link pointer", memData, {8'd0, ea - 24'd4});
        check(busy, "R9 busy during fill", 32'(busy), 32'd1);
        k++;
        ea = ea - 24'd4;
        pStall = 0;
      end else begin
        check(memValid, "R9 valid until last accept", 32'(memValid), 32'd1);
        pStall = memValid && !memReady;
        pa = memAddr;
        pd = memData;
      end
      guard++;
      @(negedge clk);
    end
    startIn  = 1'b0;
    memReady = 1'b0;
    if (cnt == 0) check(k == n, "R7 full-range write count", 32'(k), 32'(n));
    else          check(k == n, "R6 write count", 32'(k), 32'(n));
    check(done && !busy, "R9 done pulse", {30'd0, done, busy}, 32'd2);
    check(!memValid, "R6 no extra write", 32'(memValid), 32'd0);
    @(negedge clk);
    check(!done, "R9 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    logic [ADDR_W-1:0] bases [4];
    bases[0] = 24'h000040;
    bases[1] = 24'h00000B;
    bases[2] = 24'hFFFFFC;
    bases[3] = 24'h800123;
    repeat (3) @(negedge clk);
    check(!busy && !done && !memValid, "R1 reset state", {29'd0, busy, done, memValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memValid, "R1 after reset", {29'd0, busy, done, memValid}, 32'd0);
    // R6: single-entry fill gives one end marker at the base
    runXfer(24'h001000, 1, 1'b0, 1'b0);
    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < FULL_N; c++) begin
        runXfer(bases[b], c, ((c + b) % 2) == 1, (c % 5) == 3);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule